// File: doc/BRIEF.md
# Multichannel Quench Detection Core

This block watches a set of magnet voltage taps that are sampled at the same instant. Each new frame of signed 16-bit samples is first corrected by a per-channel offset and then smoothed by a per-channel first-order low-pass filter. A set of detectors then takes pairs of filtered channels and forms a weighted difference of the two, using programmable fractional coefficients. Each detector compares the magnitude of that difference against a voltage limit and counts how many consecutive frames stay above the limit. When the count reaches a programmable time limit, the detector reports a trip.

Trips are captured in sticky fault bits. The fault bits, together with the external stop and discharge-request inputs, drive a single fast-discharge output. The clear input is weak: it cannot remove a fault while the detector behind that fault is still tripped. After the parameters have been loaded through a simple write-only register port, the core runs with no outside intervention. Frames arrive at a slow rate, typically one every few hundred clocks. The core reacts to each frame within a short fixed latency.

Top module: `qd_core`

## Requirements
- R1: While reset is asserted, and after it is released with no trip and no external request, `fault_o`, `ext_o` and `fast_discharge_o` are all 0.
- R2: The register address is region·2^IDX_W + index, where IDX_W = max(clog2(N_CH), clog2(N_EQ)+3). Region 0, index c, holds the signed offset of channel c. Region 1, index c, holds the filter shift k of channel c in its low 4 bits. On each accepted frame, channel c computes xc = sat16(x − offset) and then updates its filter state as y ← y + ((xc − y) >>> k), using an arithmetic shift.
- R3: Region 2, index e·8 + f, holds field f of detector e. The fields are: 0 = coefficient a, 1 = coefficient b, 2 = x channel select, 3 = y channel select, 4 = voltage limit, 5 = time limit. The coefficients are signed Q1.15. The detector value is sat16((a·y[xsel] − b·y[ysel]) >>> 15).
- R4: A detector sees an excess when |value| is strictly greater than its unsigned voltage limit. This holds for both signs, and |−32768| is taken as 32768.
- R5: A detector counter rises by one on each frame with an excess and saturates at 65535. It returns to 0 on any frame without an excess. The detector is tripped when a frame shows an excess and the new count is ≥ the time limit. The trip status is held until the next frame.
- R6: A fault bit, once set, stays set while `clr_in` is low, regardless of later frames.
- R7: A cycle with `clr_in` high clears only those fault bits whose detector is not tripped. A tripped detector keeps its fault bit set.
- R8: `ext_o` becomes 1 on the clock after `stop_in` or `fd_req_in` is high. It is cleared by `clr_in` only while both of those inputs are low. `fast_discharge_o` is the OR of all fault bits, `ext_o`, `stop_in` and `fd_req_in`.
- R9: A frame accepted at clock edge n can set fault bits at edge n+3, and at no earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Frame strobe, one cycle per frame |
| smp_data | input | N_CH·16 | Frame; channel c in bits [16c+15:16c] |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | ADDR_W | Parameter address (IDX_W + 2 bits) |
| cfg_wdata | input | 16 | Parameter write data |
| stop_in | input | 1 | External stop |
| fd_req_in | input | 1 | External fast-discharge request |
| clr_in | input | 1 | Weak clear of faults and external status |
| fault_o | output | N_EQ | Sticky fault bit per detector |
| ext_o | output | 1 | Sticky external-request status |
| fast_discharge_o | output | 1 | Fast-discharge command |

## Verification
The bench builds the core with four channels and two detectors. This narrows the index field to four bits, so every offset, shift and detector field can be written by hand and reached from a short, readable scenario. With only two detectors, one can be tuned to probe counter persistence and strict threshold equality while the other is driven into both saturation corners of the equation stage. Because the reference model is compared on every clock, it also covers the three-edge frame-to-fault latency and the exact clock on which a weak clear takes effect.

// File: rtl/qd_pkg.sv
package qd_pkg;
    localparam int SMP_W   = 16;
    localparam int SHIFT_W = 4;
    localparam int FLD_W   = 3;
    localparam int FRAC_W  = 15;

    localparam logic [1:0] RGN_OFFSET = 2'd0;
    localparam logic [1:0] RGN_SHIFT  = 2'd1;
    localparam logic [1:0] RGN_EQ     = 2'd2;

    localparam logic [FLD_W-1:0] FLD_A    = 3'd0;
    localparam logic [FLD_W-1:0] FLD_B    = 3'd1;
    localparam logic [FLD_W-1:0] FLD_XSEL = 3'd2;
    localparam logic [FLD_W-1:0] FLD_YSEL = 3'd3;
    localparam logic [FLD_W-1:0] FLD_VTH  = 3'd4;
    localparam logic [FLD_W-1:0] FLD_TTH  = 3'd5;

    // Clamp a wide signed value into the signed sample range.
    function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [33:0] v);
        if (v > 34'sd32767) begin
            return 16'sh7FFF;
        end else if (v < -34'sd32768) begin
            return 16'sh8000;
        end else begin
            return v[SMP_W-1:0];
        end
    endfunction
endpackage

// File: rtl/qd_param_file.sv
module qd_param_file
    import qd_pkg::*;
#(
    parameter int N_CH   = 48,
    parameter int N_EQ   = 24,
    parameter int SEL_W  = 6,
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [SMP_W-1:0]                  wdata,
    output logic [N_CH-1:0][SMP_W-1:0]        off_o,
    output logic [N_CH-1:0][SHIFT_W-1:0]      shift_o,
    output logic [N_EQ-1:0][SMP_W-1:0]        ca_o,
    output logic [N_EQ-1:0][SMP_W-1:0]        cb_o,
    output logic [N_EQ-1:0][SMP_W-1:0]        vth_o,
    output logic [N_EQ-1:0][SMP_W-1:0]        tth_o,
    output logic [N_EQ-1:0][SEL_W-1:0]        xs_o,
    output logic [N_EQ-1:0][SEL_W-1:0]        ys_o
);
    typedef struct packed {
        logic [N_CH-1:0][SMP_W-1:0]   off;
        logic [N_CH-1:0][SHIFT_W-1:0] shift;
        logic [N_EQ-1:0][SMP_W-1:0]   ca;
        logic [N_EQ-1:0][SMP_W-1:0]   cb;
        logic [N_EQ-1:0][SMP_W-1:0]   vth;
        logic [N_EQ-1:0][SMP_W-1:0]   tth;
        logic [N_EQ-1:0][SEL_W-1:0]   xs;
        logic [N_EQ-1:0][SEL_W-1:0]   ys;
    } prm_t;

    prm_t prm_q, prm_d;

    logic [1:0]       rgn;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel_safe;

    assign rgn      = addr[ADDR_W-1 -: 2];
    assign idx      = addr[IDX_W-1:0];
    // An out-of-range channel select falls back to channel 0.
    assign sel_safe = (int'(wdata) < N_CH) ? wdata[SEL_W-1:0] : '0;

    always_comb begin
        prm_d = prm_q;
        if (we) begin
            for (int c = 0; c < N_CH; c++) begin
                if (idx == IDX_W'(c)) begin
                    if (rgn == RGN_OFFSET) prm_d.off[c]   = wdata;
                    if (rgn == RGN_SHIFT)  prm_d.shift[c] = wdata[SHIFT_W-1:0];
                end
            end
            for (int e = 0; e < N_EQ; e++) begin
                if (rgn == RGN_EQ && idx[IDX_W-1:FLD_W] == (IDX_W-FLD_W)'(e)) begin
                    case (idx[FLD_W-1:0])
                        FLD_A:    prm_d.ca[e]  = wdata;
                        FLD_B:    prm_d.cb[e]  = wdata;
                        FLD_XSEL: prm_d.xs[e]  = sel_safe;
                        FLD_YSEL: prm_d.ys[e]  = sel_safe;
                        FLD_VTH:  prm_d.vth[e] = wdata;
                        FLD_TTH:  prm_d.tth[e] = wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prm_q <= '0;
        else        prm_q <= prm_d;
    end

    assign off_o   = prm_q.off;
    assign shift_o = prm_q.shift;
    assign ca_o    = prm_q.ca;
    assign cb_o    = prm_q.cb;
    assign vth_o   = prm_q.vth;
    assign tth_o   = prm_q.tth;
    assign xs_o    = prm_q.xs;
    assign ys_o    = prm_q.ys;
endmodule

// File: rtl/qd_chan_filter.sv
module qd_chan_filter
    import qd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [SMP_W-1:0]  x,
    input  logic signed [SMP_W-1:0]  off,
    input  logic [SHIFT_W-1:0]       shift,
    output logic signed [SMP_W-1:0]  y_o
);
    typedef struct packed {
        logic signed [SMP_W-1:0] y;
    } flt_t;

    flt_t flt_q, flt_d;

    logic signed [SMP_W-1:0] xc;
    logic signed [SMP_W:0]   gap;
    logic signed [SMP_W:0]   step;
    logic signed [SMP_W:0]   sum;

    always_comb begin
        flt_d = flt_q;
        xc    = sat_smp(34'(x) - 34'(off));
        gap   = 17'(xc) - 17'(flt_q.y);
        step  = gap >>> shift;
        // The result lies between y and xc, so it always fits.
        sum   = 17'(flt_q.y) + step;
        if (en) flt_d.y = sum[SMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign y_o = flt_q.y;
endmodule

// File: rtl/qd_eq_detector.sv
module qd_eq_detector
    import qd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [SMP_W-1:0]  fx,
    input  logic signed [SMP_W-1:0]  fy,
    input  logic signed [SMP_W-1:0]  ca,
    input  logic signed [SMP_W-1:0]  cb,
    input  logic [SMP_W-1:0]         vth,
    input  logic [SMP_W-1:0]         tth,
    output logic                     trip_o
);
    typedef struct packed {
        logic                    v2;
        logic signed [SMP_W-1:0] eqv;
        logic [SMP_W-1:0]        cnt;
        logic                    trip;
    } det_t;

    det_t det_q, det_d;

    logic signed [2*SMP_W-1:0] prod_x;
    logic signed [2*SMP_W-1:0] prod_y;
    logic signed [2*SMP_W:0]   diff;
    logic signed [2*SMP_W:0]   scaled;
    logic [SMP_W:0]            ext17;
    logic [SMP_W:0]            mag;
    logic                      exceed;
    logic [SMP_W-1:0]          cnt_inc;

    always_comb begin
        det_d   = det_q;
        // Stage B: weighted difference in Q1.15.
        prod_x  = ca * fx;
        prod_y  = cb * fy;
        diff    = 33'(prod_x) - 33'(prod_y);
        scaled  = diff >>> FRAC_W;
        det_d.v2 = en;
        if (en) det_d.eqv = sat_smp(34'(scaled));
        // Stage C: magnitude compare and persistence counter.
        ext17   = {det_q.eqv[SMP_W-1], det_q.eqv};
        mag     = det_q.eqv[SMP_W-1] ? (~ext17 + 17'd1) : ext17;
        exceed  = mag > {1'b0, vth};
        cnt_inc = (&det_q.cnt) ? det_q.cnt : det_q.cnt + 16'd1;
        if (det_q.v2) begin
            det_d.cnt  = exceed ? cnt_inc : '0;
            det_d.trip = exceed && (cnt_inc >= tth);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign trip_o = det_q.trip;
endmodule

// File: rtl/qd_core.sv
module qd_core
    import qd_pkg::*;
#(
    parameter  int N_CH   = 48,
    parameter  int N_EQ   = 24,
    localparam int SEL_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int EQ_W   = (N_EQ > 1) ? $clog2(N_EQ) : 1,
    localparam int IDX_W  = (SEL_W > EQ_W + FLD_W) ? SEL_W : EQ_W + FLD_W,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [N_CH*SMP_W-1:0]   smp_data,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [SMP_W-1:0]        cfg_wdata,
    input  logic                    stop_in,
    input  logic                    fd_req_in,
    input  logic                    clr_in,
    output logic [N_EQ-1:0]         fault_o,
    output logic                    ext_o,
    output logic                    fast_discharge_o
);
    typedef struct packed {
        logic            v1;
        logic [N_EQ-1:0] fault;
        logic            ext;
    } core_t;

    core_t core_q, core_d;

    logic [N_CH-1:0][SMP_W-1:0]   off;
    logic [N_CH-1:0][SHIFT_W-1:0] shift;
    logic [N_EQ-1:0][SMP_W-1:0]   ca, cb, vth, tth;
    logic [N_EQ-1:0][SEL_W-1:0]   xs, ys;
    logic [N_CH-1:0][SMP_W-1:0]   filt;
    logic [N_EQ-1:0]              trip;

    qd_param_file #(
        .N_CH(N_CH), .N_EQ(N_EQ), .SEL_W(SEL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_prm (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .off_o(off), .shift_o(shift), .ca_o(ca), .cb_o(cb),
        .vth_o(vth), .tth_o(tth), .xs_o(xs), .ys_o(ys)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        qd_chan_filter u_flt (
            .clk(clk), .rst_n(rst_n), .en(smp_valid),
            .x(smp_data[c*SMP_W +: SMP_W]), .off(off[c]), .shift(shift[c]),
            .y_o(filt[c])
        );
    end

    for (genvar e = 0; e < N_EQ; e++) begin : g_eq
        qd_eq_detector u_det (
            .clk(clk), .rst_n(rst_n), .en(core_q.v1),
            .fx(filt[xs[e]]), .fy(filt[ys[e]]), .ca(ca[e]), .cb(cb[e]),
            .vth(vth[e]), .tth(tth[e]), .trip_o(trip[e])
        );
    end

    always_comb begin
        core_d       = core_q;
        core_d.v1    = smp_valid;
        // Weak clear: an active trip always wins over clr_in.
        core_d.fault = trip | (core_q.fault & ~{N_EQ{clr_in}});
        core_d.ext   = stop_in | fd_req_in | (core_q.ext & ~clr_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign fault_o          = core_q.fault;
    assign ext_o            = core_q.ext;
    assign fast_discharge_o = (|core_q.fault) | core_q.ext | stop_in | fd_req_in;
endmodule

// File: rtl/qd_core_chk.sv
module qd_core_chk #(
    parameter int N_EQ = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_in,
    input logic            fd_req_in,
    input logic            clr_in,
    input logic [N_EQ-1:0] fault_o,
    input logic            ext_o,
    input logic            fast_discharge_o,
    input logic [N_EQ-1:0] trip
);
    p_set_from_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault_o & ~($past(fault_o) | $past(trip))) == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_in |=> (($past(fault_o) & ~fault_o) == '0));

    p_weak_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_in |=> ((fault_o & $past(trip)) == $past(trip)));

    p_ext_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_in || fd_req_in) |=> ext_o);

    p_fd_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_o || (fault_o != '0)) |-> fast_discharge_o);
endmodule

bind qd_core qd_core_chk #(.N_EQ(N_EQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_in(stop_in), .fd_req_in(fd_req_in),
    .clr_in(clr_in), .fault_o(fault_o), .ext_o(ext_o),
    .fast_discharge_o(fast_discharge_o), .trip(trip)
);

// File: tb/qd_core_bench.sv
`timescale 1ns/100ps
module qd_core_bench;
    localparam int NC = 4;
    localparam int NE = 2;
    localparam int IW = 4;
    localparam int AW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_valid = 1'b0;
    logic [NC*16-1:0] smp_data = '0;
    logic            cfg_we = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [15:0]     cfg_wdata = '0;
    logic            stop_in = 1'b0, fd_req_in = 1'b0, clr_in = 1'b0;
    logic [NE-1:0]   fault_o;
    logic            ext_o, fast_discharge_o;

    qd_core #(.N_CH(NC), .N_EQ(NE)) u_qd_core (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .stop_in(stop_in), .fd_req_in(fd_req_in), .clr_in(clr_in),
        .fault_o(fault_o), .ext_o(ext_o), .fast_discharge_o(fast_discharge_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_off[NC], m_sh[NC], m_y[NC];
    int m_a[NE], m_b[NE], m_xs[NE], m_ys[NE], m_vth[NE], m_tth[NE], m_cnt[NE];
    logic [NE-1:0] m_trip = '0, m_fault = '0, calc_a = '0, calc_b = '0;
    bit va = 0, vb = 0;
    bit m_ext = 0;

    function automatic longint clamp16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic logic [NE-1:0] model_frame();
        logic [NE-1:0] r = '0;
        for (int c = 0; c < NC; c++) begin
            int x, xc, d;
            x  = int'($signed(smp_data[c*16 +: 16]));
            xc = int'(clamp16(longint'(x) - longint'(m_off[c])));
            d  = xc - m_y[c];
            m_y[c] = m_y[c] + (d >>> m_sh[c]);
        end
        for (int e = 0; e < NE; e++) begin
            longint p, v, mg;
            bit ex;
            p  = longint'(m_a[e]) * m_y[m_xs[e]] - longint'(m_b[e]) * m_y[m_ys[e]];
            v  = clamp16(p >>> 15);
            mg = (v < 0) ? -v : v;
            ex = mg > m_vth[e];
            m_cnt[e] = ex ? ((m_cnt[e] < 65535) ? m_cnt[e] + 1 : 65535) : 0;
            r[e] = ex && (m_cnt[e] >= m_tth[e]);
        end
        return r;
    endfunction

    task automatic model_write();
        int rg, ix, wd, e, f;
        rg = int'(cfg_addr) >> IW;
        ix = int'(cfg_addr) & ((1 << IW) - 1);
        wd = int'(cfg_wdata);
        if (rg == 0 && ix < NC) m_off[ix] = int'($signed(cfg_wdata));
        if (rg == 1 && ix < NC) m_sh[ix] = wd & 15;
        if (rg == 2) begin
            e = ix >> 3; f = ix & 7;
            if (e < NE) begin
                case (f)
                    0: m_a[e]   = int'($signed(cfg_wdata));
                    1: m_b[e]   = int'($signed(cfg_wdata));
                    2: m_xs[e]  = (wd < NC) ? wd : 0;
                    3: m_ys[e]  = (wd < NC) ? wd : 0;
                    4: m_vth[e] = wd;
                    5: m_tth[e] = wd;
                    default: ;
                endcase
            end
        end
    endtask

    always @(posedge clk) begin : model_step
        logic [NE-1:0] nf;
        #1;
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin m_off[c] = 0; m_sh[c] = 0; m_y[c] = 0; end
            for (int e = 0; e < NE; e++) begin
                m_a[e] = 0; m_b[e] = 0; m_xs[e] = 0; m_ys[e] = 0;
                m_vth[e] = 0; m_tth[e] = 0; m_cnt[e] = 0;
            end
            m_trip = '0; m_fault = '0; calc_a = '0; calc_b = '0; va = 0; vb = 0; m_ext = 0;
        end else begin
            nf = m_trip | (m_fault & ~{NE{clr_in}});
            m_ext = stop_in | fd_req_in | (m_ext & ~clr_in);
            if (vb) m_trip = calc_b;
            calc_b = calc_a;
            vb = va;
            va = smp_valid;
            if (smp_valid) calc_a = model_frame();
            if (cfg_we) model_write();
            m_fault = nf;
        end
    end

    // Clock-by-clock comparison against the model (R9 timing, R8 output).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 fault vs model", 32'(fault_o), 32'(m_fault));
            chk("R8 ext vs model", 32'(ext_o), 32'(m_ext));
            chk("R8 fast_discharge vs model", 32'(fast_discharge_o),
                32'((|m_fault) | m_ext | stop_in | fd_req_in));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int rg, input int ix, input int val);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = AW'((rg << IW) + ix); cfg_wdata = 16'(val);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic wr_eq(input int e, input int f, input int val);
        wr(2, e * 8 + f, val);
    endtask

    task automatic frame(input int v0, input int v1, input int v2, input int v3);
        @(posedge clk); #2;
        smp_valid = 1'b1;
        smp_data  = {16'(v3), 16'(v2), 16'(v1), 16'(v0)};
        @(posedge clk); #2;
        smp_valid = 1'b0;
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic clr_pulse();
        @(posedge clk); #2; clr_in = 1'b1;
        @(posedge clk); #2; clr_in = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1 fault in reset", 32'(fault_o), 0);
        chk("R1 fd in reset", 32'(fast_discharge_o), 0);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 fault after reset", 32'(fault_o), 0);
        chk("R1 ext after reset", 32'(ext_o), 0);
        chk("R1 fd after reset", 32'(fast_discharge_o), 0);

        wr(0, 0, 100);
        wr_eq(0, 0, 16'h4000); wr_eq(0, 1, 16'h4000);
        wr_eq(0, 2, 0); wr_eq(0, 3, 1); wr_eq(0, 4, 1000); wr_eq(0, 5, 3);
        wr_eq(1, 0, 16'h7FFF); wr_eq(1, 1, 16'h8000);
        wr_eq(1, 2, 2); wr_eq(1, 3, 3); wr_eq(1, 4, 32766); wr_eq(1, 5, 0);

        // R5: persistence, interrupted run resets the counter
        frame(5100, 0, 0, 0); frame(5100, 0, 0, 0);
        chk("R5 two excess frames no fault", 32'(fault_o), 0);
        frame(100, 0, 0, 0);
        frame(5100, 0, 0, 0); frame(5100, 0, 0, 0);
        chk("R5 counter restarted after gap", 32'(fault_o), 0);
        frame(5100, 0, 0, 0);
        chk("R5 third consecutive excess trips", 32'(fault_o), 1);

        // R6: latch holds
        frame(100, 0, 0, 0);
        chk("R6 fault held after excess ends", 32'(fault_o), 1);
        // R7: clear when not tripped
        clr_pulse();
        chk("R7 clear with no trip", 32'(fault_o), 0);
        frame(5100, 0, 0, 0); frame(5100, 0, 0, 0); frame(5100, 0, 0, 0);
        chk("R5 re-trip", 32'(fault_o), 1);
        clr_pulse();
        chk("R7 clear loses to active trip", 32'(fault_o), 1);
        frame(100, 0, 0, 0);
        clr_pulse();
        chk("R7 clear after trip gone", 32'(fault_o), 0);

        // R4: strict threshold, both signs
        wr_eq(0, 5, 0);
        frame(2100, 0, 0, 0);
        chk("R4 value equal to limit no excess", 32'(fault_o), 0);
        frame(2102, 0, 0, 0);
        chk("R4 value above limit", 32'(fault_o), 1);
        frame(100, 0, 0, 0); clr_pulse();
        frame(100, 2002, 0, 0);
        chk("R4 negative value magnitude", 32'(fault_o), 1);
        frame(100, 0, 0, 0); clr_pulse();
        chk("R4 cleared", 32'(fault_o), 0);

        // R3: saturation of the equation in both directions
        frame(100, 0, 32767, 32767);
        chk("R3 positive saturation trips", 32'(fault_o), 2);
        frame(100, 0, 0, 0); clr_pulse();
        frame(100, 0, -32768, -32768);
        chk("R3 negative saturation trips", 32'(fault_o), 2);
        frame(100, 0, 0, 0); clr_pulse();
        chk("R3 cleared", 32'(fault_o), 0);

        // R2: filter shift slows the response
        wr(1, 0, 2); wr_eq(0, 1, 0);
        frame(4100, 0, 0, 0); frame(4100, 0, 0, 0);
        chk("R2 filtered rise below limit", 32'(fault_o), 0);
        frame(4100, 0, 0, 0);
        chk("R2 filtered rise crosses limit", 32'(fault_o), 1);
        wr(0, 0, 16'h8000);
        frame(32767, 0, 0, 0);
        frame(0, 0, 0, 0);
        chk("R2 offset saturation path", 32'(fault_o), 1);
        wr(0, 0, 0); wr(1, 0, 0);
        frame(0, 0, 0, 0); clr_pulse();
        chk("R2 cleared", 32'(fault_o), 0);

        // R8: external requests
        @(posedge clk); #2 stop_in = 1'b1;
        #1 chk("R8 stop drives fd at once", 32'(fast_discharge_o), 1);
        @(posedge clk); #2 stop_in = 1'b0;
        chk("R8 stop latched", 32'(ext_o), 1);
        chk("R8 fd held by latch", 32'(fast_discharge_o), 1);
        clr_pulse();
        chk("R8 latch cleared", 32'(ext_o), 0);
        @(posedge clk); #2 fd_req_in = 1'b1; clr_in = 1'b1;
        @(posedge clk); #2 clr_in = 1'b0;
        chk("R8 request wins over clear", 32'(ext_o), 1);
        fd_req_in = 1'b0;
        clr_pulse();
        chk("R8 fd low when idle", 32'(fast_discharge_o), 0);

        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule